// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block is the digital control core of a dual-slope integrating analog-to-digital converter. It steps through a fixed measurement cycle of four phases. The first phase zeroes the system offset. The second integrates the unknown input for a fixed number of clocks. The third integrates a reference of opposite sign until an external comparator reports that the integrator has returned to zero. The fourth clears the integrator output. For each phase the block drives the enables of the analog switches around the integrator.

The result is the number of clocks spent in the third phase. Its sign comes from the input polarity, which the comparator gives at the end of the fixed window. A conversion is started by holding `run` high while the sequencer is idle. With `run` held high, conversions follow each other back to back. When `run` is low at the end of a cycle, the sequencer parks with every switch open. The integrator, comparator and switches themselves are analog parts outside this block.

Top module: `dslope_seq`

## Requirements
- R1: After reset the sequencer idles with all switches open until it samples `run` high. It then runs system zero, input integration, reference integration and integrator zero, in that order. At the end of integrator zero it starts a new system zero if `run` is high, and otherwise returns to idle.
- R2: System zero lasts `AZ_LEN` clocks, with `sw_az`, `sw_ref` and `sw_buf` closed (high) and every other switch open.
- R3: Input integration lasts `INT_LEN` clocks, with only `sw_in` closed.
- R4: The polarity is the value of `cmp` on the last clock of input integration (1 = positive). During reference integration, `sw_buf` is closed together with `sw_refp` when the polarity is positive, or `sw_refn` when it is negative. The choice does not change within the phase.
- R5: Integrator zero lasts `IZ_LEN` clocks, with only `sw_buf` and `sw_iz` closed.
- R6: Between any two phases there is exactly one clock with all seven switches open. A switch pattern never changes directly into another non-empty pattern.
- R7: Reference integration ends on the first clock on which `cmp` differs from the polarity. The result magnitude is the number of earlier clocks in that phase. The result is positive for positive polarity and negative (two's complement) for negative polarity, and `overrange` is 0.
- R8: If `cmp` still equals the polarity on the `MAX_DEINT`-th clock of reference integration, the phase ends. The result magnitude is then `MAX_DEINT`, signed by polarity, and `overrange` is 1.
- R9: `valid` is high for exactly one clock, the first clock of integrator zero. `result` and `overrange` keep their values until the next reference integration ends.
- R10: While reset is asserted, all switches are open and `valid`, `overrange` and `result` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Start / continuous-run enable |
| cmp | input | 1 | Comparator, 1 when integrator output is above zero |
| sw_in | output | 1 | Input-to-integrator switch enable |
| sw_refp | output | 1 | Positive reference switch enable |
| sw_refn | output | 1 | Negative reference switch enable |
| sw_az | output | 1 | Auto-zero switch enable |
| sw_ref | output | 1 | Reference capacitor charge switch enable |
| sw_buf | output | 1 | Buffer-to-integrator switch enable |
| sw_iz | output | 1 | Integrator output zero switch enable |
| result | output | RES_W | Signed de-integration count |
| valid | output | 1 | One-clock result strobe |
| overrange | output | 1 | De-integration reached `MAX_DEINT` |

## Verification
The assertions assume that `run` and `cmp` are synchronous to `clk` and settle between edges. They also assume that `cmp` reflects the integrator only with a one-clock lag through the modelled analog path. The bench meets both assumptions. It drives `run` and the modelled input values two nanoseconds after a rising edge. It also derives `cmp` from an integrator accumulator that updates at each rising edge from the switch enables seen before that edge. Input and reference values change only during integrator zero, when the accumulator is held at zero, so no conversion sees a value change in the middle of its integration.

// File: rtl/dslope_seq.sv
module dslope_seq #(
  parameter int AZ_LEN    = 10000,
  parameter int INT_LEN   = 10000,
  parameter int IZ_LEN    = 200,
  parameter int MAX_DEINT = 20000,
  parameter int RES_W     = $clog2(MAX_DEINT + 1) + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    run,
  input  logic                    cmp,
  output logic                    sw_in,
  output logic                    sw_refp,
  output logic                    sw_refn,
  output logic                    sw_az,
  output logic                    sw_ref,
  output logic                    sw_buf,
  output logic                    sw_iz,
  output logic signed [RES_W-1:0] result,
  output logic                    valid,
  output logic                    overrange
);

  localparam int L_A   = (AZ_LEN > INT_LEN) ? AZ_LEN : INT_LEN;
  localparam int L_B   = (L_A > IZ_LEN) ? L_A : IZ_LEN;
  localparam int L_MAX = (L_B > MAX_DEINT) ? L_B : MAX_DEINT;
  localparam int CNT_W = $clog2(L_MAX + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_AZ, S_G1, S_INT, S_G2, S_DEI, S_G3, S_IZ, S_G4
  } phase_t;

  phase_t           st;
  logic [CNT_W-1:0] cnt;
  logic             pol;
  logic [RES_W-1:0] mag_now;
  logic [RES_W-1:0] mag_max;

  assign mag_now = RES_W'(cnt);
  assign mag_max = RES_W'(MAX_DEINT);

  assign sw_in   = (st == S_INT);
  assign sw_refp = (st == S_DEI) &&  pol;
  assign sw_refn = (st == S_DEI) && !pol;
  assign sw_az   = (st == S_AZ);
  assign sw_ref  = (st == S_AZ);
  assign sw_buf  = (st == S_AZ) || (st == S_DEI) || (st == S_IZ);
  assign sw_iz   = (st == S_IZ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      pol       <= 1'b0;
      result    <= '0;
      valid     <= 1'b0;
      overrange <= 1'b0;
    end else begin
      valid <= (st == S_G3);
      case (st)
        S_IDLE: begin
          cnt <= '0;
          if (run) st <= S_AZ;
        end
        S_AZ: begin
          if (cnt == CNT_W'(AZ_LEN - 1)) begin
            st  <= S_G1;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_G1: st <= S_INT;
        S_INT: begin
          if (cnt == CNT_W'(INT_LEN - 1)) begin
            pol <= cmp;
            st  <= S_G2;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_G2: st <= S_DEI;
        S_DEI: begin
          if (cmp != pol) begin
            st        <= S_G3;
            result    <= pol ? mag_now : -mag_now;
            overrange <= 1'b0;
          end else if (cnt == CNT_W'(MAX_DEINT - 1)) begin
            st        <= S_G3;
            result    <= pol ? mag_max : -mag_max;
            overrange <= 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        S_G3: begin
          st  <= S_IZ;
          cnt <= '0;
        end
        S_IZ: begin
          if (cnt == CNT_W'(IZ_LEN - 1)) begin
            st  <= S_G4;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_G4: begin
          cnt <= '0;
          st  <= run ? S_AZ : S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dslope_seq_chk.sv
module dslope_seq_chk #(
  parameter int MAX_DEINT = 20000,
  parameter int RES_W     = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    sw_in,
  input logic                    sw_refp,
  input logic                    sw_refn,
  input logic                    sw_az,
  input logic                    sw_ref,
  input logic                    sw_buf,
  input logic                    sw_iz,
  input logic signed [RES_W-1:0] result,
  input logic                    valid,
  input logic                    overrange
);

  logic [6:0] sw_vec;
  logic signed [RES_W-1:0] lim;
  assign sw_vec = {sw_in, sw_refp, sw_refn, sw_az, sw_ref, sw_buf, sw_iz};
  assign lim = RES_W'(MAX_DEINT);

  p_az_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sw_az |-> (sw_ref && sw_buf && !sw_in && !sw_iz && !sw_refp && !sw_refn));

  p_in_alone_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sw_in |-> (sw_vec == 7'b1000000));

  p_ref_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(sw_refp && sw_refn));

  p_ref_buf_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_refp || sw_refn) |-> (sw_buf && !sw_in && !sw_az && !sw_iz));

  p_pol_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((sw_refp || sw_refn) && $past(sw_refp || sw_refn)) |-> $stable(sw_refp));

  p_iz_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sw_iz |-> (sw_vec == 7'b0000011));

  p_break_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_vec != $past(sw_vec)) |-> (sw_vec == 7'd0 || $past(sw_vec) == 7'd0));

  p_ovr_mag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && overrange) |-> (result == lim || result == -lim));

  p_valid_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);

  p_valid_iz_r9: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (sw_iz && sw_buf));

endmodule

bind dslope_seq dslope_seq_chk #(.MAX_DEINT(MAX_DEINT), .RES_W(RES_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sw_in(sw_in), .sw_refp(sw_refp), .sw_refn(sw_refn),
  .sw_az(sw_az), .sw_ref(sw_ref), .sw_buf(sw_buf), .sw_iz(sw_iz),
  .result(result), .valid(valid), .overrange(overrange)
);

// File: tb/test_dslope_seq.sv
module test_dslope_seq;
  localparam int AZ  = 20;
  localparam int INT = 100;
  localparam int IZ  = 8;
  localparam int MX  = 250;
  localparam int RW  = $clog2(MX + 1) + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0;
  logic cmp;
  logic sw_in, sw_refp, sw_refn, sw_az, sw_ref, sw_buf, sw_iz;
  logic signed [RW-1:0] result;
  logic valid, overrange;

  always #4 clk = ~clk;

  dslope_seq #(.AZ_LEN(AZ), .INT_LEN(INT), .IZ_LEN(IZ), .MAX_DEINT(MX)) i_dslope_seq (
    .clk(clk), .rst_n(rst_n), .run(run), .cmp(cmp),
    .sw_in(sw_in), .sw_refp(sw_refp), .sw_refn(sw_refn), .sw_az(sw_az),
    .sw_ref(sw_ref), .sw_buf(sw_buf), .sw_iz(sw_iz),
    .result(result), .valid(valid), .overrange(overrange)
  );

  int checks = 0;
  int errors = 0;
  int vin = 0;
  int vref = 1;
  longint acc = 0;
  int cycles = 0;
  bit done = 1'b0;

  assign cmp = (acc > 0);

  // analog integrator model
  always @(posedge clk) begin
    if (sw_az || sw_iz) acc <= 0;
    else if (sw_in) acc <= acc + vin;
    else if (sw_refp) acc <= acc - vref;
    else if (sw_refn) acc <= acc + vref;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // reference model: 0 idle,1 az,2 gap,3 int,4 gap,5 deint,6 gap,7 iz,8 gap
  int mph = 0;
  int mcnt = 0;
  bit mpol = 1'b0;
  int mres = 0;
  bit movr = 1'b0;

  function automatic logic [6:0] exp_sw(int ph, bit p);
    case (ph)
      1: return 7'b0001110;
      3: return 7'b1000000;
      5: return p ? 7'b0100010 : 7'b0010010;
      7: return 7'b0000011;
      default: return 7'b0000000;
    endcase
  endfunction

  function automatic string req_of(int ph);
    case (ph)
      0: return "R1";
      1: return "R2";
      3: return "R3";
      5: return "R4";
      7: return "R5";
      default: return "R6";
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [6:0] sv;
      bit vexp;
      sv = {sw_in, sw_refp, sw_refn, sw_az, sw_ref, sw_buf, sw_iz};
      check(sv == exp_sw(mph, mpol), req_of(mph), "switch pattern", sv, exp_sw(mph, mpol));
      vexp = (mph == 7 && mcnt == 0);
      check(valid == vexp, "R9", "valid strobe", valid, vexp);
      if (valid) begin
        longint diff;
        check(result == mres, movr ? "R8" : "R7", "result", result, mres);
        check(overrange == movr, "R8", "overrange", overrange, movr);
        if (!movr) begin
          diff = longint'(result) * vref - longint'(INT) * vin;
          check(diff >= -vref && diff <= vref, "R7", "ratio error", diff, 0);
        end
      end
      case (mph)
        0: begin mcnt = 0; if (run) mph = 1; end
        1: if (mcnt == AZ - 1) begin mph = 2; mcnt = 0; end else mcnt++;
        2: mph = 3;
        3: if (mcnt == INT - 1) begin mpol = cmp; mph = 4; mcnt = 0; end else mcnt++;
        4: mph = 5;
        5: begin
          if (cmp != mpol) begin
            mres = mpol ? mcnt : -mcnt; movr = 1'b0; mph = 6;
          end else if (mcnt == MX - 1) begin
            mres = mpol ? MX : -MX; movr = 1'b1; mph = 6;
          end else mcnt++;
        end
        6: begin mph = 7; mcnt = 0; end
        7: if (mcnt == IZ - 1) begin mph = 8; mcnt = 0; end else mcnt++;
        default: begin mcnt = 0; mph = run ? 1 : 0; end
      endcase
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      check(1'b0, "R1", "watchdog expired", cycles, 20000);
      finish_run();
    end
  end

  task automatic wait_valid();
    @(posedge valid);
    @(posedge clk); #2;
  endtask

  int vins [6] = '{37, -50, 3, 60, -70, 0};
  int vrefs[6] = '{20, 40, 7, 20, 25, 10};

  initial begin
    vin = vins[0]; vref = vrefs[0];
    repeat (4) @(posedge clk);
    @(negedge clk);
    check({sw_in, sw_refp, sw_refn, sw_az, sw_ref, sw_buf, sw_iz} == 7'd0, "R10", "reset switches", 0, 0);
    check(valid == 1'b0 && overrange == 1'b0, "R10", "reset flags", {valid, overrange}, 0);
    check(result == 0, "R10", "reset result", result, 0);
    @(posedge clk); #2;
    rst_n = 1'b1;
    repeat (10) @(posedge clk);   // idle with run low (R1)
    #2 run = 1'b1;
    for (int k = 0; k < 6; k++) begin
      wait_valid();
      if (k < 5) begin vin = vins[k+1]; vref = vrefs[k+1]; end
      else run = 1'b0;            // last conversion: park afterwards (R1)
    end
    repeat (60) @(posedge clk);
    // single-shot start: one-clock run pulse from idle (R1)
    #2 vin = 9; vref = 4; run = 1'b1;
    @(posedge clk); #2 run = 1'b0;
    wait_valid();
    check(result == 225, "R7", "single-shot result", result, 225);
    repeat (60) @(posedge clk);
    @(negedge clk);
    check(result == 225 && !overrange, "R9", "result held", result, 225);
    finish_run();
  end
endmodule